// File: doc/BRIEF.md
# Vector Length Setting Unit

This block carries out the instruction that sets the active vector length ahead of a strip-mined loop. Each request carries a 64-bit requested element count from a source register, a maximum length taken from an 11-bit immediate, and a flag marking the source specifier as the zero register. The unit works out the new active length and stores it in its vector-length register. It returns the same value, zero-extended, for writeback to the destination register.

When the requested count is between one and two times the maximum, the unit does not clamp to the maximum. It returns half the request, rounded up. This splits the last two strips of a loop evenly and avoids a short final strip. If the requested count is at least twice the maximum, the result is the maximum. A zero immediate is invalid: the result is forced to zero and an error flag goes out with the response.

Requests use a valid/ready handshake. The response is registered and comes one cycle after acceptance. It is held until the consumer accepts it. The current length can be read at any time on its own port.

Top module: `vl_set_unit`

## Requirements
- R1: After reset, `vl_o` is 0, `resp_valid_o` is 0 and `req_ready_o` is 1.
- R2: When `req_src_zero_i` is 1 and the immediate is non-zero, the result equals the immediate, whatever value is on `req_avl_i`.
- R3: When the flag is 0 and the count is no greater than the immediate, the result equals the count. A count of 0 gives 0.
- R4: When the count is greater than the immediate and less than twice the immediate, the result is the count plus one, shifted right by one.
- R5: When the count is at least twice the immediate, the result equals the immediate. This holds for every 64-bit count, including all ones, with no wrap in the comparison.
- R6: An immediate of 0 forces the result to 0 and sets `resp_err_o` to 1. `resp_err_o` is 0 for every non-zero immediate.
- R7: The writeback value `resp_vl_o` equals the new `vl_o` in the cycle the response is first valid. `vl_o` shows the new value from the cycle after acceptance.
- R8: `vl_o` changes only on an accepted request. A request offered while `req_ready_o` is 0 leaves `vl_o` and the pending response unchanged.
- R9: The response is valid one cycle after acceptance. It stays valid and stable while `resp_ready_i` is 0, and in that state `req_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_avl_i | input | XLEN (64) | Requested element count from the source register |
| req_maxvl_i | input | IMM_W (11) | Maximum vector length from the immediate |
| req_src_zero_i | input | 1 | Source specifier is the zero register |
| resp_valid_o | output | 1 | Response valid |
| resp_ready_i | input | 1 | Response accepted by the consumer |
| resp_vl_o | output | XLEN (64) | New length, zero-extended, for destination writeback |
| resp_err_o | output | 1 | Immediate was zero (invalid) |
| vl_o | output | IMM_W (11) | Current vector-length register |

## Verification
The bench builds the unit with its defaults: a 64-bit source operand and an 11-bit immediate. With these values the all-ones count can be applied directly, so a comparison that wraps is exposed. Several points are reachable as well: the 2047 maximum, its doubled threshold of 4094 and the values on either side of it, and the 4093 case whose rounded-up half is exactly the maximum. The vector table covers the loop example with a maximum of 8, where a count of 1000 gives 8, 15 gives 8 and 9 gives 5. Directed phases then hold `resp_ready_i` low to check backpressure and the blocking of new requests.

// File: rtl/vl_pkg.sv
package vl_pkg;
  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_REQ  = 2'd1,
    SEL_HALF = 2'd2,
    SEL_MAX  = 2'd3
  } vl_sel_e;
endpackage

// File: rtl/vl_calc.sv
module vl_calc
  import vl_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 11
) (
  input  logic [XLEN-1:0]  avl_i,
  input  logic [IMM_W-1:0] maxvl_i,
  input  logic             src_zero_i,
  output logic [IMM_W-1:0] vl_o,
  output logic             err_o
);
  // one extra bit: doubled max and avl+1 never wrap
  localparam int CW = XLEN + 1;

  logic [CW-1:0] avl_w, max_w, dbl_w, half_w;
  vl_sel_e       sel;

  always_comb begin
    avl_w  = {1'b0, avl_i};
    max_w  = CW'(maxvl_i);
    dbl_w  = max_w << 1;
    half_w = (avl_w + CW'(1)) >> 1;
  end

  always_comb begin
    if (maxvl_i == '0)       sel = SEL_ZERO;
    else if (src_zero_i)     sel = SEL_MAX;
    else if (avl_w <= max_w) sel = SEL_REQ;
    else if (avl_w < dbl_w)  sel = SEL_HALF;
    else                     sel = SEL_MAX;
  end

  always_comb begin
    unique case (sel)
      SEL_ZERO: vl_o = '0;
      SEL_REQ:  vl_o = avl_w[IMM_W-1:0];
      SEL_HALF: vl_o = half_w[IMM_W-1:0];
      default:  vl_o = maxvl_i;
    endcase
    err_o = (sel == SEL_ZERO);
  end
endmodule

// File: rtl/vl_state.sv
module vl_state #(
  parameter int IMM_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IMM_W-1:0] vl_d_i,
  output logic [IMM_W-1:0] vl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vl_o <= '0;
    else if (load_i) vl_o <= vl_d_i;
  end
endmodule

// File: rtl/vl_resp.sv
module vl_resp #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             ready_i,
  input  logic [IMM_W-1:0] vl_d_i,
  input  logic             err_d_i,
  output logic             valid_o,
  output logic [XLEN-1:0]  vl_o,
  output logic             err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vl_o    <= '0;
      err_o   <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      vl_o    <= XLEN'(vl_d_i);
      err_o   <= err_d_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vl_set_unit.sv
module vl_set_unit #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [XLEN-1:0]  req_avl_i,
  input  logic [IMM_W-1:0] req_maxvl_i,
  input  logic             req_src_zero_i,
  output logic             resp_valid_o,
  input  logic             resp_ready_i,
  output logic [XLEN-1:0]  resp_vl_o,
  output logic             resp_err_o,
  output logic [IMM_W-1:0] vl_o
);
  logic             accept;
  logic [IMM_W-1:0] vl_next;
  logic             err_next;

  assign req_ready_o = ~resp_valid_o | resp_ready_i;
  assign accept      = req_valid_i & req_ready_o;

  vl_calc #(.XLEN(XLEN), .IMM_W(IMM_W)) u_calc (
    .avl_i      (req_avl_i),
    .maxvl_i    (req_maxvl_i),
    .src_zero_i (req_src_zero_i),
    .vl_o       (vl_next),
    .err_o      (err_next)
  );

  vl_state #(.IMM_W(IMM_W)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .vl_d_i (vl_next),
    .vl_o   (vl_o)
  );

  vl_resp #(.XLEN(XLEN), .IMM_W(IMM_W)) u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .ready_i (resp_ready_i),
    .vl_d_i  (vl_next),
    .err_d_i (err_next),
    .valid_o (resp_valid_o),
    .vl_o    (resp_vl_o),
    .err_o   (resp_err_o)
  );
endmodule

// File: rtl/vl_set_unit_chk.sv
module vl_set_unit_chk #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [IMM_W-1:0] req_maxvl_i,
  input logic             resp_valid_o,
  input logic             resp_ready_i,
  input logic [XLEN-1:0]  resp_vl_o,
  input logic             resp_err_o,
  input logic [IMM_W-1:0] vl_o
);
  logic acc;
  assign acc = req_valid_i & req_ready_o;

  a_r7_wb_eq_vl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> resp_valid_o && (resp_vl_o == XLEN'(vl_o)));

  a_r5_vl_le_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> vl_o <= $past(req_maxvl_i));

  a_r6_err_zero_vl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_err_o) |-> resp_vl_o == '0);

  a_r8_vl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(vl_o));

  a_r9_block_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_ready_i) |-> !req_ready_o);

  a_r9_resp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_ready_i) |=> resp_valid_o && $stable(resp_vl_o) && $stable(resp_err_o));
endmodule

bind vl_set_unit vl_set_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_maxvl_i  (req_maxvl_i),
  .resp_valid_o (resp_valid_o),
  .resp_ready_i (resp_ready_i),
  .resp_vl_o    (resp_vl_o),
  .resp_err_o   (resp_err_o),
  .vl_o         (vl_o)
);

// File: tb/vl_set_unit_bench.sv
`timescale 1ns/1ps
module vl_set_unit_bench;
  localparam int XLEN  = 64;
  localparam int IMM_W = 11;
  localparam int NV    = 16;
  localparam int EW    = 1 + IMM_W + XLEN + IMM_W + 1;

  // {src_zero, maxvl, avl, exp_vl, exp_err}
  localparam logic [EW-1:0] VEC [NV] = '{
    {1'b0, 11'd8,    64'd1000, 11'd8,    1'b0},
    {1'b0, 11'd8,    64'd15,   11'd8,    1'b0},
    {1'b0, 11'd8,    64'd9,    11'd5,    1'b0},
    {1'b0, 11'd8,    64'd8,    11'd8,    1'b0},
    {1'b0, 11'd8,    64'd5,    11'd5,    1'b0},
    {1'b0, 11'd8,    64'd0,    11'd0,    1'b0},
    {1'b0, 11'd8,    64'd16,   11'd8,    1'b0},
    {1'b1, 11'd8,    64'd3,    11'd8,    1'b0},
    {1'b0, 11'd2047, 64'd4093, 11'd2047, 1'b0},
    {1'b0, 11'd2047, 64'd4094, 11'd2047, 1'b0},
    {1'b0, 11'd2047, 64'd2048, 11'd1024, 1'b0},
    {1'b0, 11'd2047, {64{1'b1}}, 11'd2047, 1'b0},
    {1'b0, 11'd3,    64'd5,    11'd3,    1'b0},
    {1'b0, 11'd1,    64'd2,    11'd1,    1'b0},
    {1'b0, 11'd0,    64'd5,    11'd0,    1'b1},
    {1'b1, 11'd0,    64'd7,    11'd0,    1'b1}
  };
  string tag_tab [NV] = '{"R5", "R4", "R4", "R3", "R3", "R3", "R5", "R2",
                          "R4", "R5", "R4", "R5", "R4", "R5", "R6", "R6"};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [XLEN-1:0]  req_avl = '0;
  logic [IMM_W-1:0] req_maxvl = '0;
  logic             req_src_zero = 1'b0;
  logic             resp_valid;
  logic             resp_ready = 1'b1;
  logic [XLEN-1:0]  resp_vl;
  logic             resp_err;
  logic [IMM_W-1:0] vl;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  vl_set_unit #(.XLEN(XLEN), .IMM_W(IMM_W)) u_vl_set_unit (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .req_valid_i    (req_valid),
    .req_ready_o    (req_ready),
    .req_avl_i      (req_avl),
    .req_maxvl_i    (req_maxvl),
    .req_src_zero_i (req_src_zero),
    .resp_valid_o   (resp_valid),
    .resp_ready_i   (resp_ready),
    .resp_vl_o      (resp_vl),
    .resp_err_o     (resp_err),
    .vl_o           (vl)
  );

  task automatic check(input string tag, input string what, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // drive at negedge, accept at posedge, sample at following negedge
  task automatic apply(input string tag, input logic sz, input logic [IMM_W-1:0] mx,
                       input logic [XLEN-1:0] avl, input logic [IMM_W-1:0] evl, input logic eerr);
    req_src_zero = sz;
    req_maxvl    = mx;
    req_avl      = avl;
    req_valid    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, "resp_vl", resp_vl, XLEN'(evl));
    check(tag, "resp_err", XLEN'(resp_err), XLEN'(eerr));
    check("R7", "vl_o", XLEN'(vl), XLEN'(evl));
    check("R9", "resp_valid", XLEN'(resp_valid), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #12;
    // R1 reset state
    check("R1", "vl_o", XLEN'(vl), 0);
    check("R1", "resp_valid", XLEN'(resp_valid), 0);
    check("R1", "req_ready", XLEN'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [EW-1:0] e;
      e = VEC[i];
      apply(tag_tab[i], e[EW-1], e[EW-2 -: IMM_W], e[IMM_W+1 +: XLEN], e[1 +: IMM_W], e[0]);
    end

    // R2: zero-register flag ignores a huge operand
    apply("R2", 1'b1, 11'd100, {64{1'b1}}, 11'd100, 1'b0);
    // R3: count equal to maximum at the widest immediate
    apply("R3", 1'b0, 11'd2047, 64'd2047, 11'd2047, 1'b0);
    // R5: high bit set but low bits small: no truncation
    apply("R5", 1'b0, 11'd8, 64'h8000_0000_0000_0003, 11'd8, 1'b0);

    // R9/R8: backpressure
    @(negedge clk);
    resp_ready = 1'b0;
    apply("R4", 1'b0, 11'd10, 64'd13, 11'd7, 1'b0);
    check("R9", "req_ready while pending", XLEN'(req_ready), 0);
    req_src_zero = 1'b0;
    req_maxvl    = 11'd20;
    req_avl      = 64'd3;
    req_valid    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8", "vl_o after blocked req", XLEN'(vl), 7);
    check("R9", "resp_vl held", resp_vl, 7);
    check("R9", "resp_valid held", XLEN'(resp_valid), 1);
    resp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", "resp_valid after accept", XLEN'(resp_valid), 0);
    check("R8", "vl_o idle", XLEN'(vl), 7);
    check("R9", "req_ready idle", XLEN'(req_ready), 1);

    // R1: asynchronous reset clears length
    rst_n = 1'b0;
    #1;
    check("R1", "vl_o after reset", XLEN'(vl), 0);
    check("R1", "resp_valid after reset", XLEN'(resp_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule